// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit RISC core whose instructions are all one word long and word aligned. On every cycle it takes the instruction class from decode and works out the address of the following instruction. The other inputs are two register operand values, a 16-bit branch offset field and a 26-bit jump target field. A new address is formed in one of four ways: by stepping to the next word, by adding an offset to the next-word address for a conditional branch, by placing the target field inside the region of the next-word address for a jump, or by loading a register value in full for a return.

For a call, the unit also produces the return address and a write strobe for the link register. The link register index is fixed at 31 and is presented on an output of its own. The PC register sits inside the block. It loads the computed address on each rising clock edge while the enable input is high. Fetch, decode and the register file are outside this block.

Top module: `npc_unit`

## Requirements
- R1: The flow class input uses these codes: 0 sequential, 1 branch-if-equal, 2 branch-if-not-equal, 3 jump, 4 jump-and-link, 5 jump-register. In the sequential class, and for the unused codes 6 and 7, next_pc_o equals pc_o + 4, with modulo 2^32 wraparound.
- R2: Branch-if-equal is taken when opa_i equals opb_i. Branch-if-not-equal is taken when the two differ. A branch that is not taken gives pc_o + 4.
- R3: A taken branch gives (pc_o + 4) plus the 16-bit offset, sign-extended to 32 bits and multiplied by 4, modulo 2^32. Backward branches are therefore possible.
- R4: A jump, and a jump-and-link, give {bits 31..28 of pc_o + 4, the 26-bit target, 2'b00}.
- R5: Jump-register gives opa_i unchanged, all 32 bits.
- R6: link_we_o is high only in the jump-and-link class. link_val_o equals pc_o + 4. link_idx_o is always 31.
- R7: A synchronous active-high reset clears pc_o to 0. Without reset, pc_o takes next_pc_o at a rising edge while en_i is high, and keeps its value while en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | PC update enable |
| flow_i | input | 3 | Instruction flow class code |
| opa_i | input | 32 | First register operand (also the jump-register source) |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Branch word offset |
| jtgt_i | input | 26 | Jump word target field |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address of the following instruction |
| link_we_o | output | 1 | Link register write strobe |
| link_idx_o | output | 5 | Link register index (31) |
| link_val_o | output | 32 | Return address |

## Verification
The corner cases that are hardest to reach all depend on the value of the current PC. One is a jump from the last word of a 256 MiB region, where the top four bits must come from the incremented address and not from the current one. Another is a branch from the last word of the address space, where the increment wraps to zero. The ports give no direct way to load the PC. The stimulus therefore first issues a jump-register with the wanted address in opa_i and the enable high. It then drops the enable and applies the instruction under test against that PC. The same routine also reaches negative offsets, including the most negative one.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN      = 32;
    localparam int OFF_W     = 16;
    localparam int JT_W      = 26;
    localparam int REGIDX_W  = 5;
    localparam int INSN_BYTES = 4;
    localparam int ALIGN_W   = $clog2(INSN_BYTES);
    localparam int REGION_W  = XLEN - JT_W - ALIGN_W;
    localparam logic [REGIDX_W-1:0] LINK_IDX = REGIDX_W'(31);
    localparam logic [XLEN-1:0] RESET_PC = '0;

    typedef enum logic [2:0] {
        FLOW_SEQ = 3'd0,
        FLOW_BEQ = 3'd1,
        FLOW_BNE = 3'd2,
        FLOW_JMP = 3'd3,
        FLOW_JAL = 3'd4,
        FLOW_JR  = 3'd5
    } flow_e;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] branch;
        logic [XLEN-1:0] jump;
    } npc_targets_t;

    function automatic logic [XLEN-1:0] scaled_offset(input logic [OFF_W-1:0] off);
        logic [XLEN-1:0] ext;
        ext = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
        return ext << ALIGN_W;
    endfunction

    function automatic logic [XLEN-1:0] region_target(input logic [XLEN-1:0] base,
                                                      input logic [JT_W-1:0] field);
        return {base[XLEN-1 -: REGION_W], field, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
(
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] imm_i,
    input  logic [JT_W-1:0]  jtgt_i,
    output npc_targets_t     tgt_o
);
    logic [XLEN-1:0] pc_plus;

    always_comb begin
        pc_plus       = pc_i + XLEN'(INSN_BYTES);
        tgt_o.seq     = pc_plus;
        tgt_o.branch  = pc_plus + scaled_offset(imm_i);
        tgt_o.jump    = region_target(pc_plus, jtgt_i);
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  flow_e           flow_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic            taken_o
);
    logic same;

    always_comb begin
        same = (opa_i == opb_i);
        case (flow_i)
            FLOW_BEQ: taken_o = same;
            FLOW_BNE: taken_o = !same;
            default:  taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  flow_e           flow_i,
    input  logic            taken_i,
    input  npc_targets_t    tgt_i,
    input  logic [XLEN-1:0] reg_tgt_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            link_we_o
);
    always_comb begin
        next_pc_o = tgt_i.seq;
        link_we_o = 1'b0;
        case (flow_i)
            FLOW_BEQ, FLOW_BNE: next_pc_o = taken_i ? tgt_i.branch : tgt_i.seq;
            FLOW_JMP:           next_pc_o = tgt_i.jump;
            FLOW_JAL: begin
                next_pc_o = tgt_i.jump;
                link_we_o = 1'b1;
            end
            FLOW_JR:            next_pc_o = reg_tgt_i;
            default:            next_pc_o = tgt_i.seq;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic [2:0]          flow_i,
    input  logic [XLEN-1:0]     opa_i,
    input  logic [XLEN-1:0]     opb_i,
    input  logic [OFF_W-1:0]    imm_i,
    input  logic [JT_W-1:0]     jtgt_i,
    output logic [XLEN-1:0]     pc_o,
    output logic [XLEN-1:0]     next_pc_o,
    output logic                link_we_o,
    output logic [REGIDX_W-1:0] link_idx_o,
    output logic [XLEN-1:0]     link_val_o
);
    logic [XLEN-1:0] pc_q;
    flow_e           flow;
    npc_targets_t    tgt;
    logic            taken;
    logic [XLEN-1:0] nxt;

    assign flow = flow_e'(flow_i);

    npc_target_gen u_tgt (
        .pc_i   (pc_q),
        .imm_i  (imm_i),
        .jtgt_i (jtgt_i),
        .tgt_o  (tgt)
    );

    npc_cond u_cond (
        .flow_i  (flow),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .taken_o (taken)
    );

    npc_select u_sel (
        .flow_i    (flow),
        .taken_i   (taken),
        .tgt_i     (tgt),
        .reg_tgt_i (opa_i),
        .next_pc_o (nxt),
        .link_we_o (link_we_o)
    );

    always_ff @(posedge clk) begin
        if (rst)       pc_q <= RESET_PC;
        else if (en_i) pc_q <= nxt;
    end

    assign pc_o       = pc_q;
    assign next_pc_o  = nxt;
    assign link_idx_o = LINK_IDX;
    assign link_val_o = tgt.seq;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                en_i,
    input logic [2:0]          flow_i,
    input logic [XLEN-1:0]     opa_i,
    input logic [XLEN-1:0]     opb_i,
    input logic [XLEN-1:0]     pc_o,
    input logic [XLEN-1:0]     next_pc_o,
    input logic                link_we_o,
    input logic [REGIDX_W-1:0] link_idx_o,
    input logic [XLEN-1:0]     link_val_o
);
    // R1
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (flow_i == 3'd0 || flow_i >= 3'd6) |-> next_pc_o == pc_o + 32'd4);

    // R2
    branch_fallthru_chk: assert property (@(posedge clk) disable iff (rst)
        ((flow_i == 3'd1 && opa_i != opb_i) || (flow_i == 3'd2 && opa_i == opb_i))
        |-> next_pc_o == pc_o + 32'd4);

    // R4
    jump_region_chk: assert property (@(posedge clk) disable iff (rst)
        (flow_i == 3'd3 || flow_i == 3'd4)
        |-> (next_pc_o[31:28] == link_val_o[31:28] && next_pc_o[1:0] == 2'b00));

    // R5
    reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
        flow_i == 3'd5 |-> next_pc_o == opa_i);

    // R6
    link_only_call_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o == (flow_i == 3'd4));

    // R6
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_val_o == pc_o + 32'd4 && link_idx_o == 5'd31));

    // R7
    pc_load_chk: assert property (@(posedge clk) disable iff (rst)
        en_i |=> pc_o == $past(next_pc_o));

    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(pc_o));

    // R7
    pc_reset_chk: assert property (@(posedge clk) rst |=> pc_o == 32'd0);
endmodule

bind npc_unit npc_unit_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .flow_i     (flow_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .pc_o       (pc_o),
    .next_pc_o  (next_pc_o),
    .link_we_o  (link_we_o),
    .link_idx_o (link_idx_o),
    .link_val_o (link_val_o)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        en_i;
    logic [2:0]  flow_i;
    logic [31:0] opa_i, opb_i;
    logic [15:0] imm_i;
    logic [25:0] jtgt_i;
    logic [31:0] pc_o, next_pc_o, link_val_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst(rst), .en_i(en_i), .flow_i(flow_i),
        .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i), .jtgt_i(jtgt_i),
        .pc_o(pc_o), .next_pc_o(next_pc_o), .link_we_o(link_we_o),
        .link_idx_o(link_idx_o), .link_val_o(link_val_o)
    );

    // start_pc, flow, opa, opb, imm, jtgt, exp_next, exp_we
    typedef struct packed {
        logic [31:0] start;
        logic [2:0]  flow;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [25:0] jt;
        logic [31:0] exp_next;
        logic        exp_we;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 3'd0, 32'd0, 32'd0, 16'h0000, 26'h0, 32'h0000_1004, 1'b0}, // R1
        '{32'h0000_1000, 3'd1, 32'd5, 32'd5, 16'h0010, 26'h0, 32'h0000_1044, 1'b0}, // R3 beq taken
        '{32'h0000_1000, 3'd1, 32'd5, 32'd6, 16'h0010, 26'h0, 32'h0000_1004, 1'b0}, // R2 beq not taken
        '{32'h0000_1000, 3'd2, 32'd5, 32'd6, 16'hFFFE, 26'h0, 32'h0000_0FFC, 1'b0}, // R3 bne backward
        '{32'h0000_1000, 3'd2, 32'd7, 32'd7, 16'hFFFE, 26'h0, 32'h0000_1004, 1'b0}, // R2 bne not taken
        '{32'hA000_0100, 3'd3, 32'd0, 32'd0, 16'h0000, 26'h3FF_FFFF, 32'hAFFF_FFFC, 1'b0}, // R4
        '{32'h0040_0010, 3'd4, 32'd0, 32'd0, 16'h0000, 26'h010_0000, 32'h0040_0000, 1'b1}, // R4 R6
        '{32'h0000_2000, 3'd5, 32'h1234_5678, 32'd0, 16'h0, 26'h0, 32'h1234_5678, 1'b0}, // R5
        '{32'h0FFF_FFFC, 3'd3, 32'd0, 32'd0, 16'h0000, 26'h000_0010, 32'h1000_0040, 1'b0}, // R4 region from pc+4
        '{32'hFFFF_FFFC, 3'd1, 32'd9, 32'd9, 16'h0001, 26'h0, 32'h0000_0004, 1'b0}, // R3 wrap
        '{32'h0010_0000, 3'd1, 32'd1, 32'd1, 16'h8000, 26'h0, 32'h000E_0004, 1'b0}, // R3 most negative
        '{32'h0000_3000, 3'd7, 32'd1, 32'd1, 16'h0004, 26'h5, 32'h0000_3004, 1'b0}, // R1 unused code
        '{32'hFFFF_FFFC, 3'd0, 32'd0, 32'd0, 16'h0000, 26'h0, 32'h0000_0000, 1'b0}  // R1 wrap
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic load_pc(input logic [31:0] v);
        @(negedge clk);
        flow_i = 3'd5; opa_i = v; en_i = 1'b1;
        @(negedge clk);
        en_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en_i = 1'b0; flow_i = 3'd0; opa_i = '0; opb_i = '0;
        imm_i = '0; jtgt_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7 reset value
        check32("R7 reset pc", pc_o, 32'h0);
        check32("R6 link index", {27'd0, link_idx_o}, 32'd31);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            load_pc(VECS[i].start);
            check32("R5 pc loaded via jump-register", pc_o, VECS[i].start);
            flow_i = VECS[i].flow; opa_i = VECS[i].a; opb_i = VECS[i].b;
            imm_i = VECS[i].imm; jtgt_i = VECS[i].jt;
            #2;
            check32("R1-vector next_pc", next_pc_o, VECS[i].exp_next);
            check32("R6 link_we", {31'd0, link_we_o}, {31'd0, VECS[i].exp_we});
            check32("R6 link_val", link_val_o, VECS[i].start + 32'd4);
        end

        // R7 hold while disabled
        load_pc(32'h0000_0800);
        flow_i = 3'd3; jtgt_i = 26'h0000_100;
        @(negedge clk); @(negedge clk);
        check32("R7 hold with en low", pc_o, 32'h0000_0800);

        // R7 update with enable: jump then sequential steps
        en_i = 1'b1;
        @(negedge clk);
        check32("R7 jump taken on edge", pc_o, 32'h0000_0400);
        flow_i = 3'd0;
        @(negedge clk); @(negedge clk);
        check32("R1 R7 two sequential steps", pc_o, 32'h0000_0408);

        // R6 call then return through link value
        flow_i = 3'd4; jtgt_i = 26'h0000_200;
        #2;
        check32("R6 call link value", link_val_o, 32'h0000_040C);
        @(negedge clk);
        check32("R4 call target", pc_o, 32'h0000_0800);
        flow_i = 3'd5; opa_i = 32'h0000_040C;
        @(negedge clk);
        check32("R5 return", pc_o, 32'h0000_040C);

        // R7 reset during run
        rst = 1'b1;
        @(negedge clk);
        check32("R7 reset mid-run", pc_o, 32'h0);
        rst = 1'b0; en_i = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule